// File: doc/BRIEF.md
# Masked Packed Word-to-Byte Narrowing Unit

This block is a SIMD execution datapath that narrows a vector of 16-bit lanes into a packed vector of 8-bit lanes. Each call picks one of three conversions through an operation code: plain truncation, signed saturation or unsigned saturation. Byte j of the output is taken from word j of the source, so the narrowed bytes pack upward from the least significant byte.

The call also carries a vector-length select, a per-lane write mask with an enable flag, a merge-or-zero select and a destination kind. For a register destination the unit returns a full 512-bit result. Inactive lanes either keep the old destination byte or are cleared. Everything from half the vector length upward is cleared. For a memory destination the unit returns store data with per-byte write enables. In that case only merging applies, so inactive bytes are simply not enabled. A reserved 4-bit field that is not all ones, or an unknown operation code, raises an illegal-encoding flag and blocks every write. Results appear one clock after the input strobe.

Top module: `narrow_w2b_unit`

## Requirements
- R1: Operation code 0x30 selects truncation: each active output byte equals bits [7:0] of its source word.
- R2: Operation code 0x20 selects signed saturation: the word is read as two's complement; values above 127 give 0x7F, values below -128 give 0x80, and others give their low byte.
- R3: Operation code 0x10 selects unsigned saturation: any word above 0x00FF gives 0xFF, and others give their low byte.
- R4: vlen_sel 0 processes 8 lanes, 1 processes 16 lanes, and 2 or 3 process 32 lanes. Output byte j (bits [8j+7:8j]) comes from source bits [16j+15:16j].
- R5: A lane within the length is active when mask_en is 0 or when lane_mask[j] is 1.
- R6: For a register destination with zero_sel 0, an inactive lane's result byte equals byte j of old_dest.
- R7: For a register destination with zero_sel 1, an inactive lane's result byte is 0x00.
- R8: For a register destination, reg_result bits from (8 × lane count) up to bit 511 are zero.
- R9: For a memory destination, store_be[j] is 1 exactly for active lanes within the length. store_data byte j holds the converted byte where enabled and zero elsewhere. zero_sel has no effect, and reg_result keeps its previous value.
- R10: If rsv_field is not 4'b1111 or op_code is not 0x30, 0x20 or 0x10, illegal_enc is 1, store_be is all zero, store_data is zero and reg_result keeps its previous value.
- R11: Outputs change one cycle after an in_valid strobe. In a cycle after in_valid was 0, out_valid, illegal_enc and store_be are 0 and reg_result keeps its previous value.
- R12: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 512 | Source vector of 32 words |
| vlen_sel | input | 2 | Vector length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| lane_mask | input | 32 | Per-lane write mask |
| mask_en | input | 1 | 1 applies lane_mask, 0 treats every lane as active |
| zero_sel | input | 1 | 1 zeroes inactive register lanes, 0 merges them |
| dest_mem | input | 1 | 1 selects a memory destination, 0 a register destination |
| old_dest | input | 256 | Previous destination bytes used for merging |
| op_code | input | 8 | Conversion code (0x30, 0x20, 0x10) |
| rsv_field | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Registered copy of in_valid |
| reg_result | output | 512 | Register-destination result |
| store_data | output | 256 | Store data for a memory destination |
| store_be | output | 32 | Per-byte store write enables |
| illegal_enc | output | 1 | Illegal encoding flag for the previous strobe |

## Verification
The assertions assume that every input is held steady across a clock edge and is known whenever in_valid is high. They decide legality from op_code and rsv_field at the strobe and use the previous cycle's strobe for every implication. The bench changes inputs only on the falling edge and drives known values at all times, including idle cycles. It mixes legal codes with a minority of bad codes and reserved values, so that both the write paths and the blocking paths are exercised under those assumptions.

// File: rtl/narrow_pkg.sv
// Package narrow_pkg
// Shared constants and types for the word-to-byte narrowing unit.
// Assumes byte-wide lanes fed by word-wide lanes; codes are 8 bits.
package narrow_pkg;
    localparam logic [7:0] OPC_TRUNC = 8'h30;
    localparam logic [7:0] OPC_SSAT  = 8'h20;
    localparam logic [7:0] OPC_USAT  = 8'h10;
    localparam logic [3:0] RSV_OK    = 4'b1111;

    typedef enum logic [1:0] {
        MODE_TRUNC = 2'd0,
        MODE_SSAT  = 2'd1,
        MODE_USAT  = 2'd2
    } narrow_mode_e;
endpackage

// File: rtl/narrow_op_decode.sv
// Module narrow_op_decode
// Turns the operation code into a conversion mode and judges legality.
// Assumes only three codes are defined; anything else, or a reserved
// field other than all ones, is illegal. Purely combinational.
module narrow_op_decode
    import narrow_pkg::*;
(
    input  logic [7:0]   op_code,
    input  logic [3:0]   rsv_field,
    output logic         legal,
    output narrow_mode_e mode
);
    logic known;

    // Map code to mode and flag unknown codes.
    always_comb begin
        mode  = MODE_TRUNC;
        known = 1'b1;
        case (op_code)
            OPC_TRUNC: mode = MODE_TRUNC;
            OPC_SSAT:  mode = MODE_SSAT;
            OPC_USAT:  mode = MODE_USAT;
            default:   known = 1'b0;
        endcase
        legal = known && (rsv_field == RSV_OK);
    end
endmodule

// File: rtl/narrow_lane_conv.sv
// Module narrow_lane_conv
// Narrows one word to one byte by truncation, signed saturation or
// unsigned saturation. Assumes WORD_W > BYTE_W. Purely combinational.
module narrow_lane_conv
    import narrow_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  narrow_mode_e      mode,
    input  logic [WORD_W-1:0] word,
    output logic [BYTE_W-1:0] narrow
);
    localparam int unsigned SGN_W = WORD_W - BYTE_W + 1;
    localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] SMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    logic [SGN_W-1:0] sgn_part;
    logic             s_fits;
    logic             u_fits;

    // Detect whether the word fits the byte range in each reading.
    always_comb begin
        sgn_part = word[WORD_W-1:BYTE_W-1];
        s_fits   = (sgn_part == '0) || (sgn_part == '1);
        u_fits   = (word[WORD_W-1:BYTE_W] == '0);
    end

    // Pick the byte for the requested conversion.
    always_comb begin
        case (mode)
            MODE_SSAT: narrow = s_fits ? word[BYTE_W-1:0]
                                       : (word[WORD_W-1] ? SMIN : SMAX);
            MODE_USAT: narrow = u_fits ? word[BYTE_W-1:0] : '1;
            default:   narrow = word[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/narrow_lane_select.sv
// Module narrow_lane_select
// Derives which lanes fall inside the vector length and which of those
// are active under the write mask. Assumes LANES divisible by 4;
// select 0 = quarter, 1 = half, 2 or 3 = all lanes.
module narrow_lane_select #(
    parameter int unsigned LANES = 32
) (
    input  logic [1:0]       vlen_sel,
    input  logic [LANES-1:0] lane_mask,
    input  logic             mask_en,
    output logic [LANES-1:0] in_range,
    output logic [LANES-1:0] active
);
    localparam int unsigned MIN_LANES = LANES / 4;

    int unsigned lane_cnt;

    // Convert the length select into a lane count.
    always_comb begin
        case (vlen_sel)
            2'd0:    lane_cnt = MIN_LANES;
            2'd1:    lane_cnt = MIN_LANES * 2;
            default: lane_cnt = LANES;
        endcase
    end

    // Build the in-range and active lane vectors.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            in_range[j] = (j < lane_cnt);
        end
        active = in_range & (mask_en ? lane_mask : {LANES{1'b1}});
    end
endmodule

// File: rtl/narrow_w2b_unit.sv
// Module narrow_w2b_unit (top)
// Masked packed word-to-byte narrowing with register and memory
// destinations, registered one cycle after in_valid.
// Assumes inputs are stable around the clock edge. old_dest only needs
// the low half of the register, since the upper half is always cleared.
module narrow_w2b_unit
    import narrow_pkg::*;
#(
    parameter int unsigned LANES  = 32,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*WORD_W-1:0]   src_vec,
    input  logic [1:0]                vlen_sel,
    input  logic [LANES-1:0]          lane_mask,
    input  logic                      mask_en,
    input  logic                      zero_sel,
    input  logic                      dest_mem,
    input  logic [LANES*BYTE_W-1:0]   old_dest,
    input  logic [7:0]                op_code,
    input  logic [3:0]                rsv_field,
    output logic                      out_valid,
    output logic [LANES*WORD_W-1:0]   reg_result,
    output logic [LANES*BYTE_W-1:0]   store_data,
    output logic [LANES-1:0]          store_be,
    output logic                      illegal_enc
);
    localparam int unsigned RES_W = LANES * WORD_W;
    localparam int unsigned ST_W  = LANES * BYTE_W;
    localparam int unsigned PAD_W = RES_W - ST_W;

    logic                          legal;
    narrow_mode_e                  mode;
    logic [LANES-1:0]              in_range;
    logic [LANES-1:0]              active;
    logic [LANES-1:0][BYTE_W-1:0]  conv_b;
    logic [LANES-1:0][BYTE_W-1:0]  reg_next;
    logic [LANES-1:0][BYTE_W-1:0]  st_next;
    logic                          wr_reg;
    logic                          wr_mem;

    narrow_op_decode u_dec (
        .op_code   (op_code),
        .rsv_field (rsv_field),
        .legal     (legal),
        .mode      (mode)
    );

    narrow_lane_select #(.LANES(LANES)) u_sel (
        .vlen_sel  (vlen_sel),
        .lane_mask (lane_mask),
        .mask_en   (mask_en),
        .in_range  (in_range),
        .active    (active)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        narrow_lane_conv #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_conv (
            .mode   (mode),
            .word   (src_vec[j*WORD_W +: WORD_W]),
            .narrow (conv_b[j])
        );
    end

    // Qualify the two write paths by strobe, legality and destination.
    always_comb begin
        wr_reg = in_valid && legal && !dest_mem;
        wr_mem = in_valid && legal && dest_mem;
    end

    // Form the per-lane register and store bytes.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (!in_range[j]) begin
                reg_next[j] = '0;
            end else if (active[j]) begin
                reg_next[j] = conv_b[j];
            end else begin
                reg_next[j] = zero_sel ? '0 : old_dest[j*BYTE_W +: BYTE_W];
            end
            st_next[j] = active[j] ? conv_b[j] : '0;
        end
    end

    // Register the strobe, flag and store outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            illegal_enc <= 1'b0;
            store_be    <= '0;
            store_data  <= '0;
        end else begin
            out_valid   <= in_valid;
            illegal_enc <= in_valid && !legal;
            store_be    <= wr_mem ? active : '0;
            store_data  <= wr_mem ? st_next : '0;
        end
    end

    // Hold or update the register-destination result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_result <= '0;
        end else if (wr_reg) begin
            reg_result <= {{PAD_W{1'b0}}, reg_next};
        end
    end
endmodule

// File: rtl/narrow_w2b_checks.sv
// Module narrow_w2b_checks
// Property checker bound into narrow_w2b_unit. Assumes inputs are
// known whenever in_valid is high.
module narrow_w2b_checks #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [1:0]              vlen_sel,
    input logic [LANES-1:0]        lane_mask,
    input logic                    mask_en,
    input logic                    dest_mem,
    input logic [7:0]              op_code,
    input logic [3:0]              rsv_field,
    input logic                    out_valid,
    input logic [LANES*WORD_W-1:0] reg_result,
    input logic [LANES-1:0]        store_be,
    input logic                    illegal_enc
);
    localparam int unsigned ST_W = LANES * BYTE_W;

    logic legal_in;

    // Legality as the requirements define it.
    always_comb begin
        legal_in = (rsv_field == 4'b1111) &&
                   (op_code == 8'h30 || op_code == 8'h20 || op_code == 8'h10);
    end

    assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_result[LANES*WORD_W-1:ST_W] == '0);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !illegal_enc && store_be == '0 && $stable(reg_result)));

    assert_illegal_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal_in) |=> (illegal_enc && store_be == '0 && $stable(reg_result)));

    assert_mem_keeps_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dest_mem) |=> $stable(reg_result));

    assert_reg_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dest_mem) |=> store_be == '0);

    assert_short_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_sel == 2'd0) |=> store_be[LANES-1:LANES/4] == '0);

    assert_mask_respected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en) |=> (store_be & ~$past(lane_mask)) == '0);
endmodule

bind narrow_w2b_unit narrow_w2b_checks #(
    .LANES(LANES), .WORD_W(WORD_W), .BYTE_W(BYTE_W)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .vlen_sel    (vlen_sel),
    .lane_mask   (lane_mask),
    .mask_en     (mask_en),
    .dest_mem    (dest_mem),
    .op_code     (op_code),
    .rsv_field   (rsv_field),
    .out_valid   (out_valid),
    .reg_result  (reg_result),
    .store_be    (store_be),
    .illegal_enc (illegal_enc)
);

// File: tb/narrow_w2b_unit_test.sv
// Bench narrow_w2b_unit_test
// Behavioural reference model compared against the unit on every clock.
module narrow_w2b_unit_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [511:0] src_vec;
    logic [1:0]   vlen_sel;
    logic [31:0]  lane_mask;
    logic         mask_en;
    logic         zero_sel;
    logic         dest_mem;
    logic [255:0] old_dest;
    logic [7:0]   op_code;
    logic [3:0]   rsv_field;
    logic         out_valid;
    logic [511:0] reg_result;
    logic [255:0] store_data;
    logic [31:0]  store_be;
    logic         illegal_enc;

    int checks = 0;
    int errors = 0;
    logic [511:0] exp_reg;

    always #4 clk = ~clk;

    narrow_w2b_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .vlen_sel(vlen_sel), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_sel(zero_sel), .dest_mem(dest_mem), .old_dest(old_dest),
        .op_code(op_code), .rsv_field(rsv_field), .out_valid(out_valid),
        .reg_result(reg_result), .store_data(store_data),
        .store_be(store_be), .illegal_enc(illegal_enc)
    );

    function automatic logic [7:0] ref_conv(input logic [7:0] op, input logic [15:0] w);
        int sv;
        sv = $signed(w);
        if (op == 8'h20) begin
            if (sv > 127) return 8'h7F;
            if (sv < -128) return 8'h80;
            return w[7:0];
        end
        if (op == 8'h10) return (int'(w) > 255) ? 8'hFF : w[7:0];
        return w[7:0];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Apply current inputs for one clock and compare every output.
    task automatic cycle(input string tag);
        int kl;
        bit legal, act;
        logic e_valid, e_ill;
        logic [31:0] e_be;
        logic [255:0] e_data;
        logic [511:0] nreg;
        kl = (vlen_sel == 2'd0) ? 8 : (vlen_sel == 2'd1) ? 16 : 32;
        legal = (rsv_field == 4'hF) &&
                (op_code == 8'h30 || op_code == 8'h20 || op_code == 8'h10);
        e_valid = in_valid;
        e_ill = in_valid && !legal;
        e_be = '0;
        e_data = '0;
        if (in_valid && legal) begin
            nreg = '0;
            for (int j = 0; j < kl; j++) begin
                act = !mask_en || lane_mask[j];
                if (dest_mem) begin
                    if (act) begin
                        e_be[j] = 1'b1;
                        e_data[j*8 +: 8] = ref_conv(op_code, src_vec[j*16 +: 16]);
                    end
                end else if (act) begin
                    nreg[j*8 +: 8] = ref_conv(op_code, src_vec[j*16 +: 16]);
                end else begin
                    nreg[j*8 +: 8] = zero_sel ? 8'h00 : old_dest[j*8 +: 8];
                end
            end
            if (!dest_mem) exp_reg = nreg;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "out_valid", {511'b0, out_valid}, {511'b0, e_valid});
        check(tag, "illegal_enc", {511'b0, illegal_enc}, {511'b0, e_ill});
        check(tag, "reg_result", reg_result, exp_reg);
        check(tag, "store_data", {256'b0, store_data}, {256'b0, e_data});
        check(tag, "store_be", {480'b0, store_be}, {480'b0, e_be});
    endtask

    task automatic setup(input logic [7:0] op, input logic [1:0] vl,
                         input logic men, input logic [31:0] msk,
                         input logic zs, input logic mem);
        in_valid = 1'b1; op_code = op; vlen_sel = vl; mask_en = men;
        lane_mask = msk; zero_sel = zs; dest_mem = mem; rsv_field = 4'hF;
    endtask

    task automatic fill_pattern(input logic [15:0] p0, input logic [15:0] p1,
                                input logic [15:0] p2, input logic [15:0] p3,
                                input logic [15:0] p4, input logic [15:0] p5,
                                input logic [15:0] p6, input logic [15:0] p7);
        logic [15:0] pat [8];
        pat = '{p0, p1, p2, p3, p4, p5, p6, p7};
        for (int j = 0; j < 32; j++) src_vec[j*16 +: 16] = pat[j % 8];
    endtask

    task automatic fill_random();
        for (int j = 0; j < 16; j++) src_vec[j*32 +: 32] = $urandom;
        for (int j = 0; j < 8; j++) old_dest[j*32 +: 32] = $urandom;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; src_vec = '0; vlen_sel = 2'd2;
        lane_mask = '0; mask_en = 1'b0; zero_sel = 1'b0; dest_mem = 1'b0;
        old_dest = '0; op_code = 8'h30; rsv_field = 4'hF;
        exp_reg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        check("R12", "out_valid", {511'b0, out_valid}, 512'b0);
        check("R12", "reg_result", reg_result, 512'b0);
        check("R12", "store_be", {480'b0, store_be}, 512'b0);
        check("R12", "store_data", {256'b0, store_data}, 512'b0);
        check("R12", "illegal_enc", {511'b0, illegal_enc}, 512'b0);

        // R1: truncation on full length
        fill_random();
        setup(8'h30, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        cycle("R1");
        // R2: signed saturation boundaries
        fill_pattern(16'h007F, 16'h0080, 16'hFF80, 16'hFF7F,
                     16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000);
        setup(8'h20, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        cycle("R2");
        // R3: unsigned saturation boundaries
        fill_pattern(16'h00FF, 16'h0100, 16'hFFFF, 16'h0000,
                     16'h8000, 16'h0001, 16'h7F80, 16'h00A5);
        setup(8'h10, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        cycle("R3");
        // R4: each length select, placement by lane index
        for (int v = 0; v < 4; v++) begin
            fill_random();
            setup(8'h30, v[1:0], 1'b0, 32'h0, 1'b0, 1'b0);
            cycle("R4");
        end
        // R5: mask disabled ignores a zero mask
        fill_random();
        setup(8'h20, 2'd2, 1'b0, 32'h0, 1'b1, 1'b0);
        cycle("R5");
        // R6: merging keeps old bytes
        fill_random();
        setup(8'h10, 2'd2, 1'b1, 32'hA5A5_0F0F, 1'b0, 1'b0);
        cycle("R6");
        // R7: zeroing clears inactive bytes
        fill_random();
        setup(8'h30, 2'd1, 1'b1, 32'h3C3C_C3C3, 1'b1, 1'b0);
        cycle("R7");
        // R8: shrink from full result to shortest length
        fill_random();
        setup(8'h30, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        cycle("R8");
        setup(8'h30, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0);
        cycle("R8");
        // R9: memory destination, zero select has no effect
        fill_random();
        setup(8'h20, 2'd1, 1'b1, 32'hFFFF_5A69, 1'b1, 1'b1);
        cycle("R9");
        setup(8'h10, 2'd2, 1'b0, 32'h0, 1'b1, 1'b1);
        cycle("R9");
        // R10: bad reserved field and unknown code
        fill_random();
        setup(8'h30, 2'd2, 1'b0, 32'h0, 1'b0, 1'b0);
        rsv_field = 4'hE;
        cycle("R10");
        setup(8'h40, 2'd2, 1'b0, 32'h0, 1'b0, 1'b1);
        cycle("R10");
        // R11: idle cycles keep everything quiet
        in_valid = 1'b0;
        dest_mem = 1'b1;
        cycle("R11");
        cycle("R11");

        // Mixed random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ops [4];
            ops = '{8'h30, 8'h20, 8'h10, 8'h31};
            fill_random();
            setup(ops[$urandom_range(0, 3)], 2'($urandom_range(0, 3)),
                  1'($urandom), $urandom, 1'($urandom), 1'($urandom));
            in_valid = ($urandom_range(0, 7) != 0);
            rsv_field = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'hF;
            cycle("random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule